// File: doc/BRIEF.md
# Receive frame address filter

This block sits between a receive deframer and the receive buffer. It watches a byte stream that carries a start-of-frame strobe, a byte-valid strobe and an end-of-frame marker. The first valid byte after each start-of-frame is the frame's address. That byte is compared with an 8-bit match value held in a 32-bit configuration register. If the frame is accepted, the address, control and data bytes go to the buffer write port, in order, one cycle after they arrive. If the frame is rejected, every remaining byte of that frame is withheld and the block waits for the next start-of-frame.

Filtering is active only while the match-enable input is high. When it is low, every frame is passed through. While filtering is active, the all-ones address is treated as broadcast and is always accepted. The filter behaves the same at every link rate: it has no rate input, and its decision depends only on the byte stream and the configuration.

For each frame that reaches its end marker, the block gives a one-cycle report that says whether the frame was discarded, so that later logic can count rejected frames. When the receive-enable input is low, the block stays idle, writes nothing and forgets any frame that was in progress.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, the match value register reads as 0x00000000, and `wr_en`, `wr_last`, `frame_done` and `frame_dropped` are all low.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the match value. From the next cycle on, `cfg_rdata` returns it in bits 7:0, and bits 31:8 always read as zero.
- R3: With `match_en` high, a frame whose address byte equals the match value is written out in full. Each valid byte appears on `wr_data` with `wr_en` high exactly one cycle after it was presented, and `wr_last` is high with the final byte.
- R4: With `match_en` high, a frame whose address byte equals neither the match value nor 0xFF produces no write for any of its bytes.
- R5: With `match_en` high, an address byte of 0xFF is always accepted and its frame is written out in full.
- R6: With `match_en` low, every frame is written out in full, whatever its address.
- R7: A cycle with `in_sof` high, in any state, starts a new frame. Any byte presented in that cycle is discarded, and the next valid byte is taken as the new address. The interrupted frame gets no report.
- R8: While `rx_en` is low, nothing is written and nothing is reported. A frame in progress is abandoned, and the block then waits for a new `in_sof`.
- R9: One cycle after the final byte of a frame (`in_valid` and `in_eof` high together), `frame_done` pulses for one cycle. `frame_dropped` is high in that same cycle exactly when the frame was rejected.
- R10: Valid bytes that arrive when no frame is open (before any start-of-frame, or after an end-of-frame) are ignored.
- R11: `in_eof` counts only together with `in_valid`. An end marker without a valid byte leaves the frame open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable; low forces the idle state |
| match_en | input | 1 | Address filtering enable |
| cfg_we | input | 1 | Match value register write strobe |
| cfg_wdata | input | 8 | Match value to store |
| cfg_rdata | output | 32 | Match value register read data, upper bits zero |
| in_sof | input | 1 | Start-of-frame strobe |
| in_valid | input | 1 | Byte valid strobe |
| in_eof | input | 1 | Marks the byte presented with it as the last of the frame |
| in_data | input | 8 | Received byte |
| wr_en | output | 1 | Buffer write strobe |
| wr_data | output | 8 | Buffer write byte |
| wr_last | output | 1 | Written byte is the last of its frame |
| frame_done | output | 1 | One-cycle end-of-frame report |
| frame_dropped | output | 1 | Reported frame was discarded |

## Verification
The checker watches, on every cycle, the properties that hold locally. A write always carries the byte presented one cycle earlier, and never a byte from a start-of-frame cycle. A low `rx_en` silences the next cycle. A rejecting state never produces a write. Drop reports exclude writes, and pass reports coincide with a last byte. The register echoes writes, and its upper bits stay zero. The bench's scenarios are needed for the rest: that the accept decision is right for matching, broadcast, mismatching and unfiltered addresses, that a restart mid-frame re-takes the address from the following byte, that stray bytes and lone end markers change nothing, and that a frame keeps its decision until it ends. A reference model checks these cycle by cycle, over directed frames and random traffic.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int RXF_BYTE_W = 8;

  typedef enum logic [1:0] {
    RXF_IDLE = 2'd0,
    RXF_ADDR = 2'd1,
    RXF_PASS = 2'd2,
    RXF_DROP = 2'd3
  } rxf_state_e;

  // Accept decision for an address byte: unfiltered, exact hit, or broadcast.
  function automatic logic rxf_accept(
    input logic                  filt_on,
    input logic [RXF_BYTE_W-1:0] addr,
    input logic [RXF_BYTE_W-1:0] match
  );
    logic is_bcast;
    is_bcast = &addr;
    return (!filt_on) || (addr == match) || is_bcast;
  endfunction
endpackage

// File: rtl/rxf_match_reg.sv
module rxf_match_reg #(
  parameter int DATA_W = 8,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value,
  output logic [REG_W-1:0]  rdata
);
  localparam int PAD_W = REG_W - DATA_W;

  logic [DATA_W-1:0] val_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  val_q <= '0;
    else if (we) val_q <= wdata;
  end

  assign value = val_q;
  assign rdata = {{PAD_W{1'b0}}, val_q};
endmodule

// File: rtl/rxf_decider.sv
module rxf_decider
  import rxf_pkg::*;
#(
  parameter int DATA_W = RXF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              match_en,
  input  logic [DATA_W-1:0] match_val,
  input  logic              sof,
  input  logic              valid,
  input  logic              eof,
  input  logic [DATA_W-1:0] data,
  output logic              emit,
  output logic              emit_last,
  output logic [DATA_W-1:0] emit_data,
  output logic              rep_done,
  output logic              rep_drop,
  output logic              addr_strobe,
  output logic              addr_hit,
  output rxf_state_e        state
);
  rxf_state_e st_q, st_n;
  logic       take;

  assign take        = rx_en && !sof && valid;
  assign addr_strobe = take && (st_q == RXF_ADDR);
  assign addr_hit    = rxf_accept(match_en, data, match_val);
  assign emit_data   = data;
  assign state       = st_q;

  always_comb begin
    st_n      = st_q;
    emit      = 1'b0;
    emit_last = 1'b0;
    rep_done  = 1'b0;
    rep_drop  = 1'b0;
    if (!rx_en) begin
      st_n = RXF_IDLE;
    end else if (sof) begin
      st_n = RXF_ADDR;
    end else if (take) begin
      unique case (st_q)
        RXF_ADDR: begin
          emit      = addr_hit;
          emit_last = addr_hit && eof;
          if (eof) begin
            rep_done = 1'b1;
            rep_drop = !addr_hit;
            st_n     = RXF_IDLE;
          end else begin
            st_n = addr_hit ? RXF_PASS : RXF_DROP;
          end
        end
        RXF_PASS: begin
          emit      = 1'b1;
          emit_last = eof;
          if (eof) begin
            rep_done = 1'b1;
            st_n     = RXF_IDLE;
          end
        end
        RXF_DROP: begin
          if (eof) begin
            rep_done = 1'b1;
            rep_drop = 1'b1;
            st_n     = RXF_IDLE;
          end
        end
        default: st_n = RXF_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= RXF_IDLE;
    else        st_q <= st_n;
  end
endmodule

// File: rtl/rxf_out_stage.sv
module rxf_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  logic              emit_last,
  input  logic [DATA_W-1:0] emit_data,
  input  logic              rep_done,
  input  logic              rep_drop,
  output logic              wr_en,
  output logic              wr_last,
  output logic [DATA_W-1:0] wr_data,
  output logic              frame_done,
  output logic              frame_dropped
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en         <= 1'b0;
      wr_last       <= 1'b0;
      wr_data       <= '0;
      frame_done    <= 1'b0;
      frame_dropped <= 1'b0;
    end else begin
      wr_en         <= emit;
      wr_last       <= emit && emit_last;
      wr_data       <= emit ? emit_data : wr_data;
      frame_done    <= rep_done;
      frame_dropped <= rep_done && rep_drop;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int DATA_W = RXF_BYTE_W,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              match_en,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              in_sof,
  input  logic              in_valid,
  input  logic              in_eof,
  input  logic [DATA_W-1:0] in_data,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_last,
  output logic              frame_done,
  output logic              frame_dropped
);
  logic [DATA_W-1:0] match_val;
  logic              emit, emit_last, rep_done, rep_drop;
  logic [DATA_W-1:0] emit_data;
  logic              addr_strobe, addr_hit;
  rxf_state_e        dec_state;
  logic              st_is_drop;

  rxf_match_reg #(.DATA_W(DATA_W), .REG_W(REG_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .value (match_val),
    .rdata (cfg_rdata)
  );

  rxf_decider #(.DATA_W(DATA_W)) u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en       (rx_en),
    .match_en    (match_en),
    .match_val   (match_val),
    .sof         (in_sof),
    .valid       (in_valid),
    .eof         (in_eof),
    .data        (in_data),
    .emit        (emit),
    .emit_last   (emit_last),
    .emit_data   (emit_data),
    .rep_done    (rep_done),
    .rep_drop    (rep_drop),
    .addr_strobe (addr_strobe),
    .addr_hit    (addr_hit),
    .state       (dec_state)
  );

  assign st_is_drop = (dec_state == RXF_DROP);

  rxf_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .emit          (emit),
    .emit_last     (emit_last),
    .emit_data     (emit_data),
    .rep_done      (rep_done),
    .rep_drop      (rep_drop),
    .wr_en         (wr_en),
    .wr_last       (wr_last),
    .wr_data       (wr_data),
    .frame_done    (frame_done),
    .frame_dropped (frame_dropped)
  );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int DATA_W = 8,
  parameter int REG_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              in_sof,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              cfg_we,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [REG_W-1:0]  cfg_rdata,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_last,
  input logic              frame_done,
  input logic              frame_dropped,
  input logic              st_drop,
  input logic              addr_strobe,
  input logic              addr_hit
);
  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[REG_W-1:DATA_W] == '0);

  // R2
  reg_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata[DATA_W-1:0] == $past(cfg_wdata));

  // R3
  write_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(in_valid) && !$past(in_sof) && wr_data == $past(in_data)));

  // R3
  last_has_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last |-> wr_en);

  // R4
  drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_drop |=> !wr_en);

  // R4
  reject_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_strobe && !addr_hit) |=> !wr_en);

  // R8
  rx_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!wr_en && !frame_done));

  // R9
  drop_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_dropped |-> (frame_done && !wr_en));

  // R9
  pass_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_dropped) |-> (wr_en && wr_last));
endmodule

bind rx_addr_filter rxf_checker #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_en         (rx_en),
  .in_sof        (in_sof),
  .in_valid      (in_valid),
  .in_data       (in_data),
  .cfg_we        (cfg_we),
  .cfg_wdata     (cfg_wdata),
  .cfg_rdata     (cfg_rdata),
  .wr_en         (wr_en),
  .wr_data       (wr_data),
  .wr_last       (wr_last),
  .frame_done    (frame_done),
  .frame_dropped (frame_dropped),
  .st_drop       (st_is_drop),
  .addr_strobe   (addr_strobe),
  .addr_hit      (addr_hit)
);

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0, match_en = 1'b0, cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        in_sof = 1'b0, in_valid = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = '0;
  logic        wr_en, wr_last, frame_done, frame_dropped;
  logic [7:0]  wr_data;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .match_en(match_en),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .in_sof(in_sof), .in_valid(in_valid), .in_eof(in_eof), .in_data(in_data),
    .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
    .frame_done(frame_done), .frame_dropped(frame_dropped)
  );

  // Reference model state: 0 idle, 1 awaiting address, 2 passing, 3 dropping
  int         m_st = 0;
  logic [7:0] m_val = 8'h00;
  logic       e_wr, e_last, e_done, e_drop;
  logic [7:0] e_data;
  string      e_tag;

  function automatic bit ref_keep(input logic fen, input logic [7:0] a, input logic [7:0] v);
    if (!fen) return 1'b1;
    if (a == 8'hFF) return 1'b1;
    return a == v;
  endfunction

  task automatic model_step();
    bit keep;
    e_wr = 0; e_last = 0; e_done = 0; e_drop = 0; e_data = 8'h00; e_tag = "R10";
    if (!rx_en) begin
      m_st = 0; e_tag = "R8";
    end else if (in_sof) begin
      m_st = 1; e_tag = "R7";
    end else if (in_valid) begin
      if (m_st == 1) begin
        keep = ref_keep(match_en, in_data, m_val);
        e_tag = !match_en ? "R6" : (in_data == m_val) ? "R3" : (in_data == 8'hFF) ? "R5" : "R4";
        e_wr = keep; e_data = in_data; e_last = keep && in_eof;
        if (in_eof) begin e_done = 1; e_drop = !keep; m_st = 0; e_tag = {e_tag, "/R9"}; end
        else m_st = keep ? 2 : 3;
      end else if (m_st == 2) begin
        e_tag = "R3"; e_wr = 1; e_data = in_data; e_last = in_eof;
        if (in_eof) begin e_done = 1; m_st = 0; e_tag = "R3/R9"; end
      end else if (m_st == 3) begin
        e_tag = "R4";
        if (in_eof) begin e_done = 1; e_drop = 1; m_st = 0; e_tag = "R4/R9"; end
      end
    end else if (in_eof) begin
      e_tag = "R11";
    end
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One cycle: inputs already set at a negedge; advance and compare.
  task automatic cyc(input bit s, input bit v, input bit e, input logic [7:0] d);
    in_sof = s; in_valid = v; in_eof = e; in_data = d;
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(wr_en == e_wr, e_tag, "wr_en", 32'(wr_en), 32'(e_wr));
    if (e_wr) chk(wr_data == e_data, e_tag, "wr_data", 32'(wr_data), 32'(e_data));
    chk(wr_last == e_last, e_tag, "wr_last", 32'(wr_last), 32'(e_last));
    chk(frame_done == e_done, e_tag, "frame_done", 32'(frame_done), 32'(e_done));
    chk(frame_dropped == e_drop, e_tag, "frame_dropped", 32'(frame_dropped), 32'(e_drop));
    if (cfg_we) m_val = cfg_wdata;
    chk(cfg_rdata == {24'h0, m_val}, "R2", "cfg_rdata", cfg_rdata, {24'h0, m_val});
    cfg_we = 1'b0;
  endtask

  task automatic set_match(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    cyc(0, 0, 0, 8'h00);
  endtask

  task automatic frame(input logic [7:0] a, input int n);
    cyc(1, 0, 0, 8'h00);
    cyc(0, 1, n == 0, a);
    for (int i = 0; i < n; i++) cyc(0, 1, i == n - 1, 8'(8'h10 + i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 32'h0, "R1", "cfg_rdata", cfg_rdata, 32'h0);
    chk(!wr_en && !wr_last && !frame_done && !frame_dropped, "R1", "outputs",
        {28'h0, wr_en, wr_last, frame_done, frame_dropped}, 32'h0);

    rx_en = 1'b1; match_en = 1'b1;
    set_match(8'h5A);                    // R2
    cyc(0, 1, 0, 8'h5A);                 // R10 stray byte, no frame open
    frame(8'h5A, 3);                     // R3 match
    frame(8'h33, 3);                     // R4 mismatch
    frame(8'hFF, 2);                     // R5 broadcast
    match_en = 1'b0;
    frame(8'h33, 2);                     // R6 unfiltered
    match_en = 1'b1;
    frame(8'h5A, 0);                     // single-byte frame, R3/R9
    frame(8'h44, 0);                     // single-byte reject, R4/R9
    // R7 restart mid-frame: byte with sof discarded, next byte is address
    cyc(1, 0, 0, 8'h00); cyc(0, 1, 0, 8'h5A); cyc(0, 1, 0, 8'h01);
    cyc(1, 1, 0, 8'h5A); cyc(0, 1, 0, 8'h77); cyc(0, 1, 1, 8'h88);
    // R8 rx_en low mid-frame, then bytes continue and are ignored
    cyc(1, 0, 0, 8'h00); cyc(0, 1, 0, 8'h5A);
    rx_en = 1'b0; cyc(0, 1, 0, 8'h02); cyc(0, 1, 0, 8'h03);
    rx_en = 1'b1; cyc(0, 1, 0, 8'h04); cyc(0, 1, 1, 8'h05);
    // R11 lone eof keeps the frame open
    cyc(1, 0, 0, 8'h00); cyc(0, 1, 0, 8'h5A); cyc(0, 0, 1, 8'h00);
    cyc(0, 1, 0, 8'h06); cyc(0, 1, 1, 8'h07);
    cyc(0, 1, 1, 8'h08);                 // R10 byte after end
    set_match(8'h00);
    frame(8'h00, 2);                     // R3 match on zero value

    // Random traffic
    for (int k = 0; k < 6000; k++) begin
      logic [7:0] d;
      int sel;
      if (($urandom % 64) == 0) rx_en = ~rx_en;
      if (!rx_en && ($urandom % 4) == 0) rx_en = 1'b1;
      if (($urandom % 97) == 0) match_en = ~match_en;
      if (($urandom % 150) == 0) begin cfg_we = 1'b1; cfg_wdata = 8'($urandom); end
      sel = int'($urandom % 4);
      d = (sel == 0) ? m_val : (sel == 1) ? 8'hFF : 8'($urandom);
      cyc(($urandom % 12) == 0, ($urandom % 4) != 0, ($urandom % 8) == 0, d);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule